// File: doc/BRIEF.md
# Supply Voltage Monitor Controller

This block is the digital half of a low-voltage supervisor. Each clock it receives a digitized code for the supply voltage. It compares that code against a pair of thresholds, one for falling and one for rising, taken from one of two selectable levels. The lower level is meant for forcing a reset. The higher level gives earlier warning. The comparison result is held with hysteresis in a trip flag. Software can poll this flag, and the same flag can drive a reset request to the system reset logic.

A small configuration register sets the behaviour. It holds four bits: a power-down bit that silences the monitor, a reset-inhibit bit that leaves only the polled flag active, a stop-mode enable, and the level select. A synchronous power-on reset loads defaults that leave the monitor enabled, with resets enabled, the lower level selected and stop-mode operation off. Switching to the higher level while the supply is at or below that level's falling threshold makes the block raise a reset request on the next sample.

Top module: `vmon_ctrl`

## Requirements
- R1: After `rst`, `low_flag` and `rst_req` are 0, and the configuration takes its defaults: monitor powered, resets enabled, lower level selected, stop-mode operation off.
- R2: While the configuration's power-down bit is 1, every sample drives `low_flag` and `rst_req` to 0, whatever the supply code.
- R3: While the reset-inhibit bit is 1, `rst_req` stays 0 and `low_flag` still tracks the supply with hysteresis.
- R4: While the monitor is active and resets are enabled, `rst_req` equals `low_flag` after every sample.
- R5: Level select 0 uses the thresholds LO_FALL and LO_RISE. Level select 1 uses HI_FALL and HI_RISE.
- R6: While the monitor is active, a sample at or below the falling threshold sets the trip flag. A sample at or above the rising threshold clears it. A sample strictly between the two keeps the previous value.
- R7: If level select is written to 1 while the supply code is at or below HI_FALL and resets are enabled, `rst_req` is 1 after the first sample that follows the write.
- R8: While `stop_mode` is 1, the monitor is inactive unless the stop-enable bit is 1. While inactive, both outputs are 0.
- R9: A sample taken at a clock edge appears on the outputs after that edge. A configuration written at an edge applies from the next edge's sample onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_we | input | 1 | Loads the four configuration bits at this edge |
| cfg_pwr_off | input | 1 | Power-down bit: 1 silences the monitor |
| cfg_rst_off | input | 1 | Reset-inhibit bit: 1 gives polled-only operation |
| cfg_stop_en | input | 1 | 1 keeps the monitor running in stop mode |
| cfg_hi_sel | input | 1 | Level select: 0 lower level, 1 higher level |
| stop_mode | input | 1 | System is in stop mode |
| vdd_code | input | CODE_W | Digitized supply sample |
| low_flag | output | 1 | Polled trip status |
| rst_req | output | 1 | Registered reset request |

## Verification
The bench builds the block with a 10-bit code, a lower pair of 200/240 and a higher pair of 400/440. With these values, codes that lie inside one hysteresis band sit clearly outside the other pair, so the effect of the level select can be seen from the flag alone. Samples placed exactly on each threshold, and one code above or below it, check the inclusive compares. Configuration writes are placed on the same cycle as a sample, which exposes the one-sample delay before a new setting takes effect.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    // Configuration word held by the block
    typedef struct packed {
        logic pwr_off;   // 1: monitor powered down
        logic rst_off;   // 1: reset request inhibited (polled only)
        logic stop_en;   // 1: keep running in stop mode
        logic hi_sel;    // level select
    } vmon_cfg_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } vmon_lvl_e;

    localparam int unsigned NUM_LEVELS = 2;
    localparam vmon_cfg_t   CFG_DEFAULT = '{pwr_off: 1'b0, rst_off: 1'b0,
                                            stop_en: 1'b0, hi_sel: 1'b0};

    // Monitor runs when powered and not parked by stop mode
    function automatic logic monitor_active(input vmon_cfg_t c, input logic stop);
        return !c.pwr_off && (!stop || c.stop_en);
    endfunction

    function automatic vmon_lvl_e level_of(input vmon_cfg_t c);
        return c.hi_sel ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/vmon_cfg_reg.sv
module vmon_cfg_reg
    import vmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  vmon_cfg_t cfg_d,
    output vmon_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_DEFAULT;
        else if (we)
            cfg_q <= cfg_d;
    end
endmodule

// File: rtl/vmon_thresh.sv
module vmon_thresh
    import vmon_pkg::*;
#(
    parameter int unsigned CODE_W  = 10,
    parameter int unsigned LO_FALL = 200,
    parameter int unsigned LO_RISE = 240,
    parameter int unsigned HI_FALL = 400,
    parameter int unsigned HI_RISE = 440
) (
    input  vmon_lvl_e         level,
    output logic [CODE_W-1:0] fall,
    output logic [CODE_W-1:0] rise
);
    localparam int unsigned FALL_TAB [NUM_LEVELS] = '{LO_FALL, HI_FALL};
    localparam int unsigned RISE_TAB [NUM_LEVELS] = '{LO_RISE, HI_RISE};

    logic [CODE_W-1:0] fall_lvl [NUM_LEVELS];
    logic [CODE_W-1:0] rise_lvl [NUM_LEVELS];

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
        localparam int unsigned F = FALL_TAB[i];
        localparam int unsigned R = RISE_TAB[i];
        assign fall_lvl[i] = F[CODE_W-1:0];
        assign rise_lvl[i] = R[CODE_W-1:0];
    end

    always_comb begin
        fall = fall_lvl[int'(level)];
        rise = rise_lvl[int'(level)];
    end
endmodule

// File: rtl/vmon_hyst.sv
module vmon_hyst #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              req_en,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] fall,
    input  logic [CODE_W-1:0] rise,
    output logic              trip_q,
    output logic              req_q
);
    logic trip_d;

    always_comb begin
        if (!active)
            trip_d = 1'b0;
        else if (code <= fall)
            trip_d = 1'b1;
        else if (code >= rise)
            trip_d = 1'b0;
        else
            trip_d = trip_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            trip_q <= trip_d;
            req_q  <= trip_d && req_en;
        end
    end
endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
    import vmon_pkg::*;
#(
    parameter int unsigned CODE_W  = 10,
    parameter int unsigned LO_FALL = 200,
    parameter int unsigned LO_RISE = 240,
    parameter int unsigned HI_FALL = 400,
    parameter int unsigned HI_RISE = 440
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_pwr_off,
    input  logic              cfg_rst_off,
    input  logic              cfg_stop_en,
    input  logic              cfg_hi_sel,
    input  logic              stop_mode,
    input  logic [CODE_W-1:0] vdd_code,
    output logic              low_flag,
    output logic              rst_req
);
    vmon_cfg_t         cfg_d;
    vmon_cfg_t         cfg_q;
    logic [CODE_W-1:0] thr_fall;
    logic [CODE_W-1:0] thr_rise;
    logic              active;
    logic              req_en;

    always_comb begin
        cfg_d.pwr_off = cfg_pwr_off;
        cfg_d.rst_off = cfg_rst_off;
        cfg_d.stop_en = cfg_stop_en;
        cfg_d.hi_sel  = cfg_hi_sel;
        active        = monitor_active(cfg_q, stop_mode);
        req_en        = !cfg_q.rst_off;
    end

    vmon_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    vmon_thresh #(
        .CODE_W  (CODE_W),
        .LO_FALL (LO_FALL),
        .LO_RISE (LO_RISE),
        .HI_FALL (HI_FALL),
        .HI_RISE (HI_RISE)
    ) u_thr (
        .level (level_of(cfg_q)),
        .fall  (thr_fall),
        .rise  (thr_rise)
    );

    vmon_hyst #(.CODE_W(CODE_W)) u_hyst (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .req_en (req_en),
        .code   (vdd_code),
        .fall   (thr_fall),
        .rise   (thr_rise),
        .trip_q (low_flag),
        .req_q  (rst_req)
    );
endmodule

// File: rtl/vmon_ctrl_chk.sv
module vmon_ctrl_chk
    import vmon_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_mode,
    input logic [CODE_W-1:0] vdd_code,
    input vmon_cfg_t         cfg_q,
    input logic [CODE_W-1:0] thr_fall,
    input logic [CODE_W-1:0] thr_rise,
    input logic              low_flag,
    input logic              rst_req
);
    logic past_ok;
    logic act;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign act = !cfg_q.pwr_off && (!stop_mode || cfg_q.stop_en);

    p_pwr_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(cfg_q.pwr_off) |-> !low_flag && !rst_req);

    p_inhibit_no_req_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(cfg_q.rst_off) |-> !rst_req);

    p_req_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> low_flag);

    p_req_tracks_flag_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(act && !cfg_q.rst_off) |-> rst_req == low_flag);

    p_set_at_fall_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(act && (vdd_code <= thr_fall)) |-> low_flag);

    p_clear_at_rise_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(act && (vdd_code >= thr_rise) && (vdd_code > thr_fall)) |-> !low_flag);

    p_hold_in_band_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(act && (vdd_code > thr_fall) && (vdd_code < thr_rise))
        |-> low_flag == $past(low_flag));

    p_stop_parks_r8: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(stop_mode && !cfg_q.stop_en) |-> !low_flag && !rst_req);
endmodule

bind vmon_ctrl vmon_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_mode (stop_mode),
    .vdd_code  (vdd_code),
    .cfg_q     (cfg_q),
    .thr_fall  (thr_fall),
    .thr_rise  (thr_rise),
    .low_flag  (low_flag),
    .rst_req   (rst_req)
);

// File: tb/tb_vmon_ctrl.sv
module tb_vmon_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 10;
    localparam int NVEC       = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_pwr_off = 1'b0;
    logic              cfg_rst_off = 1'b0;
    logic              cfg_stop_en = 1'b0;
    logic              cfg_hi_sel = 1'b0;
    logic              stop_mode = 1'b0;
    logic [CODE_W-1:0] vdd_code = '0;
    logic              low_flag;
    logic              rst_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmon_ctrl #(
        .CODE_W(CODE_W), .LO_FALL(200), .LO_RISE(240), .HI_FALL(400), .HI_RISE(440)
    ) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pwr_off(cfg_pwr_off),
        .cfg_rst_off(cfg_rst_off), .cfg_stop_en(cfg_stop_en), .cfg_hi_sel(cfg_hi_sel),
        .stop_mode(stop_mode), .vdd_code(vdd_code), .low_flag(low_flag), .rst_req(rst_req)
    );

    typedef struct packed {
        logic        we, pwr, rsoff, sten, hi, stop;
        logic [9:0]  code;
        logic        ef, er;
    } vec_t;

    // Each row is one clock; expected outputs follow that edge, using the
    // configuration in force before any write on the same row (R9).
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd500,1'b0,1'b0},  // 0  R5 above
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd240,1'b0,1'b0},  // 1  R6 at rise
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd201,1'b0,1'b0},  // 2  R6 hold low
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd200,1'b1,1'b1},  // 3  R6 at fall
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd220,1'b1,1'b1},  // 4  R6 hold
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd239,1'b1,1'b1},  // 5  R6 hold
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd240,1'b0,1'b0},  // 6  R6 clear
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd100,1'b1,1'b1},  // 7  R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd300,1'b0,1'b0},  // 8  R5
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,10'd300,1'b0,1'b0},  // 9  R9 write hi
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd300,1'b1,1'b1},  // 10 R7 immediate
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd420,1'b1,1'b1},  // 11 R6 hold hi
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd440,1'b0,1'b0},  // 12 R6 clear hi
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd401,1'b0,1'b0},  // 13 R6 hold hi
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd400,1'b1,1'b1},  // 14 R5 hi fall
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,10'd450,1'b0,1'b0},  // 15 write inhibit
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd150,1'b1,1'b0},  // 16 R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd450,1'b0,1'b0},  // 17 R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd350,1'b1,1'b0},  // 18 R3
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,10'd350,1'b1,1'b0},  // 19 R9 write off
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd100,1'b0,1'b0},  // 20 R2
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd0,  1'b0,1'b0},  // 21 R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,10'd100,1'b0,1'b0},  // 22 R2 write on
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd100,1'b1,1'b1},  // 23 R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,10'd100,1'b0,1'b0},  // 24 R8
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,10'd100,1'b0,1'b0},  // 25 R8
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,10'd100,1'b0,1'b0},  // 26 R8 write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,10'd100,1'b1,1'b1},  // 27 R8 stop on
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd300,1'b0,1'b0},  // 28 R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd220,1'b0,1'b0}   // 29 R6 hold
    };

    task automatic check(input string req, input logic ef, input logic er);
        checks++;
        if (low_flag !== ef || rst_req !== er) begin
            errors++;
            $display("FAIL %s: low_flag=%b rst_req=%b expected %b %b", req, low_flag, rst_req, ef, er);
        end
    endtask

    task automatic step(input logic we, input logic pwr, input logic rsoff,
                        input logic sten, input logic hi, input logic stop,
                        input logic [CODE_W-1:0] code);
        cfg_we = we; cfg_pwr_off = pwr; cfg_rst_off = rsoff;
        cfg_stop_en = sten; cfg_hi_sel = hi; stop_mode = stop; vdd_code = code;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        vdd_code = 10'd100;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].we, VECS[i].pwr, VECS[i].rsoff, VECS[i].sten,
                 VECS[i].hi, VECS[i].stop, VECS[i].code);
            check($sformatf("vector %0d", i), VECS[i].ef, VECS[i].er);
        end

        // R1: reset restores defaults; set non-default config first
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd300);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd300);
        check("R1 pre-reset hi level", 1'b1, 1'b0);
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd100);
        check("R1 outputs in reset", 1'b0, 1'b0);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd300);
        check("R1 default lower level", 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd100);
        check("R1 default resets enabled", 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd100);
        check("R1 default stop off", 1'b0, 1'b0);

        // R7: select hi while code equals HI_FALL exactly
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd400);
        check("R7 lower level idle", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd400);
        check("R9 write not yet applied", 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd400);
        check("R7 immediate request at HI_FALL", 1'b1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule